// File: doc/BRIEF.md
# Page Memory-Type Attribute Table

This block keeps eight programmable memory-attribute slots and turns three attribute bits taken from a page-translation entry into a 3-bit memory type. Software reaches the whole table as one 64-bit configuration register, selected by a register number on a simple read/write port. Translation logic drives a lookup port with the three selector bits and a flag. The flag is set when the entry was fetched from a directory level that is being used as a final table.

Each slot is one byte wide. Only its low three bits are kept. The upper five bits read back as zero. A configuration write is checked before it takes effect. If any slot in the write carries one of the two undefined type codes, the whole write is dropped and an error flag is raised. After reset the table gives the same results as the older scheme that used only two page bits, write-through and cache-disable.

The lookup path is purely combinational from the lookup inputs and the stored table. It answers in the same cycle whenever translation is enabled. When translation is disabled the result is forced to zero.

Top module: `pg_memtype_table`

## Requirements
- R1: After reset the slots hold, from slot 0 to slot 7, the types 6, 4, 7, 0, 6, 4, 7, 0. Slot k occupies bits [8k+7:8k] of the 64-bit register.
- R2: The lookup index is {sel_hi, sel_cd, sel_wt}, with sel_hi as the most significant bit. When lk_en=1, lk_type equals the low three bits of the indexed slot, in the same cycle.
- R3: When lk_dir=1, sel_hi is treated as 0, so only slots 0 to 3 can be selected.
- R4: When lk_en=0, lk_type is 0.
- R5: A write with reg_wr=1 and reg_num=0x277 whose slots all carry valid codes (0, 1, 4, 5, 6 or 7 in bits [2:0]) updates the table from the next cycle. The five upper bits of every slot are discarded.
- R6: If any slot of such a write carries code 2 or 3, the table is left unchanged. In that case wr_err is 1 in the following cycle. wr_err is 0 in the cycle after any other cycle.
- R7: Writes to any other register number do not change the table and do not raise wr_err.
- R8: rd_data is registered. In the cycle after reg_rd=1, rd_data holds the table if the register number was 0x277, with reserved bits as zero. Otherwise it holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_num | input | 32 | Register number for the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| wr_data | input | 64 | Write data, one byte per slot |
| rd_data | output | 64 | Registered read data |
| wr_err | output | 1 | Write was rejected in the previous cycle |
| lk_en | input | 1 | Translation enabled |
| lk_dir | input | 1 | Entry came from a directory used as a table |
| sel_wt | input | 1 | Write-through page bit |
| sel_cd | input | 1 | Cache-disable page bit |
| sel_hi | input | 1 | Third attribute page bit |
| lk_type | output | 3 | Resolved memory type |

## Verification
A corrupt slot shows up at once on lk_type, in the same cycle as the first lookup that selects it. It also shows up one cycle after a read of the register. A bad validity check shows as a slot that changed, or one that should have changed and did not. It also shows as a wrong wr_err one cycle after the write. The bench sweeps all 32 lookup input combinations against several table contents, and injects each undefined code into each slot.

// File: rtl/pg_memtype_pkg.sv
// Shared constants and types for the page memory-type table.
// Assumes one byte per slot with a 3-bit type held in the low bits.
package pg_memtype_pkg;
    localparam int SLOTS     = 8;
    localparam int SLOT_W    = 8;
    localparam int TYPE_W    = 3;
    localparam int IDX_W     = $clog2(SLOTS);
    localparam int REG_W     = SLOTS * SLOT_W;
    localparam logic [31:0] TABLE_REG = 32'h0000_0277;

    typedef logic [TYPE_W-1:0] mtype_t;

    // Memory type codes.
    localparam mtype_t MT_UC  = 3'd0;
    localparam mtype_t MT_WC  = 3'd1;
    localparam mtype_t MT_WT  = 3'd4;
    localparam mtype_t MT_WP  = 3'd5;
    localparam mtype_t MT_WB  = 3'd6;
    localparam mtype_t MT_UCW = 3'd7;

    // Reset contents of a slot, as seen through the legacy two-bit encoding.
    function automatic mtype_t reset_type(input int k);
        case (k % 4)
            0: return MT_WB;
            1: return MT_WT;
            2: return MT_UCW;
            default: return MT_UC;
        endcase
    endfunction

    // A type code is defined unless it is 2 or 3.
    function automatic logic type_ok(input mtype_t t);
        return !(t == 3'd2 || t == 3'd3);
    endfunction
endpackage

// File: rtl/pg_memtype_check.sv
// Decodes a 64-bit write image and flags whether every slot carries a defined code.
// Assumes the image layout of one byte per slot, with slot 0 in the low byte.
module pg_memtype_check
    import pg_memtype_pkg::*;
(
    input  logic [REG_W-1:0] image,
    output logic             all_ok
);
    logic [SLOTS-1:0] slot_ok;

    // One validity test per slot.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign slot_ok[k] = type_ok(image[k*SLOT_W +: TYPE_W]);
    end

    // The write is accepted only if every slot is valid.
    assign all_ok = &slot_ok;
endmodule

// File: rtl/pg_memtype_store.sv
// Holds the eight type slots and applies validated whole-table writes.
// Assumes the caller has already decoded the register number and validity.
module pg_memtype_store
    import pg_memtype_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] image,
    output mtype_t           slots [SLOTS]
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        // Slot register: reset to the legacy value, or load the low type bits.
        always_ff @(posedge clk) begin
            if (!rst_n)    slots[k] <= reset_type(k);
            else if (load) slots[k] <= image[k*SLOT_W +: TYPE_W];
        end

        // R5
        // Every stored slot always holds a defined code.
        slot_def_chk: assert property (@(posedge clk) disable iff (!rst_n)
            type_ok(slots[k]));
    end
endmodule

// File: rtl/pg_memtype_lookup.sv
// Resolves the page attribute bits into a memory type.
// Assumes the slot contents are stable during the lookup; the path is combinational.
module pg_memtype_lookup
    import pg_memtype_pkg::*;
(
    input  mtype_t slots [SLOTS],
    input  logic   lk_en,
    input  logic   lk_dir,
    input  logic   sel_wt,
    input  logic   sel_cd,
    input  logic   sel_hi,
    output mtype_t lk_type
);
    logic [IDX_W-1:0] idx;

    // Form the index; a directory-as-table entry has no third bit.
    always_comb idx = {sel_hi & ~lk_dir, sel_cd, sel_wt};

    // Select the slot, or return zero when translation is off.
    always_comb lk_type = lk_en ? slots[idx] : MT_UC;

    // R3
    always_comb dir_low_chk: assert (!(lk_en && lk_dir) || idx[IDX_W-1] == 1'b0);
endmodule

// File: rtl/pg_memtype_table.sv
// Top level: register access to the attribute table plus the lookup port.
// Assumes single-cycle strobes and a synchronous active-low reset.
module pg_memtype_table
    import pg_memtype_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       reg_num,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              wr_err,
    input  logic              lk_en,
    input  logic              lk_dir,
    input  logic              sel_wt,
    input  logic              sel_cd,
    input  logic              sel_hi,
    output logic [TYPE_W-1:0] lk_type
);
    logic   hit;
    logic   img_ok;
    logic   load;
    mtype_t slots [SLOTS];
    logic [REG_W-1:0] image_rd;

    // Decode the register address.
    always_comb hit = (reg_num == TABLE_REG);

    pg_memtype_check u_check (.image(wr_data), .all_ok(img_ok));

    // Apply only addressed writes whose codes are all defined.
    always_comb load = reg_wr && hit && img_ok;

    pg_memtype_store u_store (
        .clk(clk), .rst_n(rst_n), .load(load), .image(wr_data), .slots(slots)
    );

    pg_memtype_lookup u_lookup (
        .slots(slots), .lk_en(lk_en), .lk_dir(lk_dir),
        .sel_wt(sel_wt), .sel_cd(sel_cd), .sel_hi(sel_hi), .lk_type(lk_type)
    );

    // Build the read image, zeroing the reserved bits.
    for (genvar k = 0; k < SLOTS; k++) begin : g_rd
        assign image_rd[k*SLOT_W +: SLOT_W] = {{(SLOT_W-TYPE_W){1'b0}}, slots[k]};
    end

    // Register the read data and the write error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            wr_err  <= 1'b0;
        end else begin
            rd_data <= (reg_rd && hit) ? image_rd : '0;
            wr_err  <= reg_wr && hit && !img_ok;
        end
    end

    // R6
    rej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit && !img_ok) |=> (wr_err && $stable(slots[0]) && $stable(slots[7])));
    // R7
    other_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |=> (!wr_err && $stable(slots[3])));
    // R8
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd) |=> (rd_data == '0));
    // R5
    wr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit && img_ok) |=> (slots[1] == $past(wr_data[10:8])));
endmodule

// File: tb/tb_pg_memtype_table.sv
module tb_pg_memtype_table;
    localparam int CLK_T = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] reg_num = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [63:0] wr_data = 0;
    logic [63:0] rd_data;
    logic        wr_err;
    logic        lk_en = 0, lk_dir = 0, sel_wt = 0, sel_cd = 0, sel_hi = 0;
    logic [2:0]  lk_type;

    int total = 0, bad = 0;
    logic [2:0] model [8];

    always #(CLK_T/2) clk = ~clk;

    pg_memtype_table dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_img();
        logic [63:0] v = '0;
        for (int k = 0; k < 8; k++) v[k*8 +: 3] = model[k];
        return v;
    endfunction

    // Sweep every lookup input combination against the model.
    task automatic sweep(input string tag);
        for (int v = 0; v < 32; v++) begin
            {lk_en, lk_dir, sel_hi, sel_cd, sel_wt} = v[4:0];
            #1;
            if (!lk_en) chk({tag, " R4"}, 64'(lk_type), 64'd0);
            else if (lk_dir) chk({tag, " R3"}, 64'(lk_type), 64'(model[{1'b0, sel_cd, sel_wt}]));
            else chk({tag, " R2"}, 64'(lk_type), 64'(model[{sel_hi, sel_cd, sel_wt}]));
        end
    endtask

    // One register access, then sample away from the edge.
    task automatic access(input logic [31:0] n, input logic w, input logic r, input logic [63:0] d);
        @(negedge clk);
        reg_num = n; reg_wr = w; reg_rd = r; wr_data = d;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0;
    endtask

    task automatic read_chk(input string req);
        access(32'h277, 0, 1, 0);
        chk(req, rd_data, model_img());
    endtask

    initial begin
        logic [63:0] d;
        for (int k = 0; k < 8; k++) model[k] = 3'((k % 4 == 0) ? 6 : (k % 4 == 1) ? 4 : (k % 4 == 2) ? 7 : 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 rst err", 64'(wr_err), 0);
        chk("R8 rst rd", rd_data, 0);
        read_chk("R1 reset image");
        sweep("reset");
        // Valid writes with junk in reserved bits.
        d = 64'hF8_E9_D6_C5_B4_A1_90_8F; // codes 0,7? compute
        for (int k = 0; k < 8; k++) d[k*8 +: 3] = 3'((k == 2 || k == 3) ? k + 2 : k);
        access(32'h277, 1, 0, d);
        chk("R5 no err", 64'(wr_err), 0);
        for (int k = 0; k < 8; k++) model[k] = d[k*8 +: 3];
        read_chk("R5 write1");
        sweep("w1");
        d = 64'h0001_0405_0607_0000 | 64'hE0E0_E0E0_E0E0_E0E0;
        access(32'h277, 1, 0, d);
        for (int k = 0; k < 8; k++) model[k] = d[k*8 +: 3];
        read_chk("R5 write2");
        sweep("w2");
        // Each undefined code in each slot is rejected.
        for (int k = 0; k < 8; k++) begin
            for (int c = 2; c <= 3; c++) begin
                d = model_img();
                d[k*8 +: 3] = 3'(c);
                access(32'h277, 1, 0, d);
                chk("R6 err flag", 64'(wr_err), 1);
                @(negedge clk);
                chk("R6 err clears", 64'(wr_err), 0);
                read_chk("R6 unchanged");
            end
        end
        // Other register numbers.
        access(32'h276, 1, 0, 64'h0707_0707_0707_0707);
        chk("R7 no err", 64'(wr_err), 0);
        access(32'h278, 1, 0, 64'h0202_0202_0202_0202);
        chk("R7 no err bad data", 64'(wr_err), 0);
        read_chk("R7 unchanged");
        access(32'h276, 0, 1, 0);
        chk("R8 other reg", rd_data, 0);
        @(negedge clk);
        chk("R8 idle zero", rd_data, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_T * 20000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule